// File: doc/BRIEF.md
# Folded Symmetric FIR Decimator

This block low-pass filters a stream of signed 12-bit converter samples and keeps one result for every eight inputs. It sits ahead of a band-analysis filter bank. The filter has 49 taps with even symmetry about the centre tap. Each pair of samples that share a coefficient is added first. One shared multiplier then works through the 24 pairs and the centre tap, one term per clock.

Samples enter through a circular delay line with a strobe. The eighth accepted sample starts a multiply-accumulate run. The full-precision sum is rounded, clamped to 16 bits and presented with a one-cycle valid pulse. The processing clock can be far faster than the sample rate. Samples may arrive on consecutive clocks, except while a result is being computed.

Top module: `fir_decim8`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `out_data` are cleared to 0 and every delay-line entry is cleared to zero, so samples older than reset contribute nothing.
- R2: A sample is accepted on a rising edge where `in_valid` is high and no result is pending. Accepted samples may arrive on back-to-back clocks, and the most recent 49 accepted samples form the filter history.
- R3: Each eighth accepted sample starts one result. `out_valid` is high for exactly one cycle, beginning at the 26th rising edge after the edge that accepted that eighth sample.
- R4: Before rounding, the result is the sum over j = 0..48 of c(j)·x[n−j], where x[n] is the eighth sample and c(j) = 16·(min(j, 48−j) + 1). The centre weight is 400 and the weights sum to 10000.
- R5: Rounding adds 128 to the sum and then shifts it arithmetically right by 8 bits, which rounds halves toward positive infinity.
- R6: A rounded value above 32767 is output as 32767, and one below −32768 is output as −32768.
- R7: An `in_valid` strobe on any of the 26 rising edges after the edge that accepted an eighth sample is dropped. The sample is not stored, and it does not count toward the next group of eight.
- R8: `out_data` keeps its last value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that offers one input sample |
| in_data | input | 12 | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 16 | Signed rounded and saturated result |

## Verification
The stimulus patterns are chosen to isolate different faults:

- **Single impulse:** picks out the weights one at a time in history order. This exposes a pairing or pointer error that a constant input would hide.
- **Constant inputs:**
  - Small values such as 3 and −3 exercise the rounding offset.
  - A level of 800 lands just under the positive limit.
  - Full-scale inputs of both signs force saturation.
- **Continuous strobe with random data:** stresses the window in which samples are dropped and the group-of-eight count that follows it.
- **Randomly spaced strobes:** compared against a behavioural model on every clock. This separates timing faults from arithmetic faults.

// File: rtl/fir_dec_pkg.sv
package fir_dec_pkg;

    localparam int TAPS   = 49;
    localparam int DECIM  = 8;
    localparam int IN_W   = 12;
    localparam int COEF_W = 16;
    localparam int OUT_W  = 16;
    localparam int SHIFT  = 8;

    localparam int HALF   = (TAPS - 1) / 2;
    localparam int PTR_W  = $clog2(TAPS);
    localparam int K_W    = $clog2(HALF + 1);
    localparam int PH_W   = $clog2(DECIM);
    localparam int PRE_W  = IN_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(HALF + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_EMIT
    } mac_state_e;

    typedef struct packed {
        logic [PTR_W-1:0] hi;
        logic [PTR_W-1:0] lo;
        logic [K_W-1:0]   k;
    } tap_sel_t;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(TAPS - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(TAPS - 1) : p - 1'b1;
    endfunction

    // Weight for pair index k (k = HALF is the centre tap).
    function automatic logic signed [COEF_W-1:0] coef_at(input logic [K_W-1:0] k);
        int v;
        v = 16 * (int'(k) + 1);
        return v[COEF_W-1:0];
    endfunction

    function automatic logic signed [OUT_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] half;
        logic signed [ACC_W-1:0] r;
        logic signed [ACC_W-1:0] hi_lim;
        logic signed [ACC_W-1:0] lo_lim;
        half = '0;
        half[SHIFT-1] = 1'b1;
        hi_lim = '0;
        hi_lim[OUT_W-2:0] = '1;
        lo_lim = ~hi_lim;
        r = acc + half;
        r = r >>> SHIFT;
        if (r > hi_lim) begin
            r = hi_lim;
        end else if (r < lo_lim) begin
            r = lo_lim;
        end
        return r[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/fir_dec_delay.sv
module fir_dec_delay
    import fir_dec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic signed [IN_W-1:0] wr_data,
    input  logic [PTR_W-1:0]       rd_hi_ptr,
    input  logic [PTR_W-1:0]       rd_lo_ptr,
    output logic [PTR_W-1:0]       wr_ptr,
    output logic signed [IN_W-1:0] rd_hi,
    output logic signed [IN_W-1:0] rd_lo
);

    logic signed [IN_W-1:0] mem [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && wr_ptr == PTR_W'(g)) begin
                mem[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= ptr_inc(wr_ptr);
        end
    end

    assign rd_hi = mem[rd_hi_ptr];
    assign rd_lo = mem[rd_lo_ptr];

endmodule

// File: rtl/fir_dec_ctrl.sv
module fir_dec_ctrl
    import fir_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PTR_W-1:0] wr_ptr,
    output logic             accept,
    output logic             busy,
    output tap_sel_t         sel,
    output logic             centre,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             emit
);

    mac_state_e       state;
    logic [PH_W-1:0]  phase;
    logic             start;

    assign accept  = in_valid && (state == ST_IDLE);
    assign start   = accept && (phase == PH_W'(DECIM - 1));
    assign busy    = (state != ST_IDLE);
    assign centre  = (sel.k == K_W'(HALF));
    assign acc_clr = start;
    assign acc_en  = (state == ST_RUN);
    assign emit    = (state == ST_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= '0;
            sel   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        phase <= (phase == PH_W'(DECIM - 1)) ? '0 : phase + 1'b1;
                    end
                    if (start) begin
                        state  <= ST_RUN;
                        sel.hi <= wr_ptr;            // newest sample
                        sel.lo <= ptr_inc(wr_ptr);   // oldest sample
                        sel.k  <= '0;
                    end
                end
                ST_RUN: begin
                    sel.hi <= ptr_dec(sel.hi);
                    sel.lo <= ptr_inc(sel.lo);
                    sel.k  <= sel.k + 1'b1;
                    if (centre) begin
                        state <= ST_EMIT;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/fir_dec_mac.sv
module fir_dec_mac
    import fir_dec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    centre,
    input  logic [K_W-1:0]          k,
    input  logic signed [IN_W-1:0]  a,
    input  logic signed [IN_W-1:0]  b,
    output logic signed [ACC_W-1:0] acc
);

    logic signed [PRE_W-1:0]  pre;
    logic signed [COEF_W-1:0] coef;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        if (centre) begin
            pre = {a[IN_W-1], a};
        end else begin
            pre = {a[IN_W-1], a} + {b[IN_W-1], b};
        end
        coef = coef_at(k);
        prod = $signed({{COEF_W{pre[PRE_W-1]}}, pre}) *
               $signed({{PRE_W{coef[COEF_W-1]}}, coef});
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
        end
    end

endmodule

// File: rtl/fir_dec_out.sv
module fir_dec_out
    import fir_dec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    emit,
    input  logic signed [ACC_W-1:0] acc,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_data <= round_sat(acc);
            end
        end
    end

endmodule

// File: rtl/fir_decim8.sv
module fir_decim8
    import fir_dec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    logic                    accept;
    logic                    busy;
    logic                    centre;
    logic                    acc_clr;
    logic                    acc_en;
    logic                    emit;
    tap_sel_t                sel;
    logic [PTR_W-1:0]        wr_ptr;
    logic signed [IN_W-1:0]  rd_hi;
    logic signed [IN_W-1:0]  rd_lo;
    logic signed [ACC_W-1:0] acc;

    fir_dec_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .wr_ptr   (wr_ptr),
        .accept   (accept),
        .busy     (busy),
        .sel      (sel),
        .centre   (centre),
        .acc_clr  (acc_clr),
        .acc_en   (acc_en),
        .emit     (emit)
    );

    fir_dec_delay u_delay (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept),
        .wr_data   (in_data),
        .rd_hi_ptr (sel.hi),
        .rd_lo_ptr (sel.lo),
        .wr_ptr    (wr_ptr),
        .rd_hi     (rd_hi),
        .rd_lo     (rd_lo)
    );

    fir_dec_mac u_mac (
        .clk    (clk),
        .rst    (rst),
        .clr    (acc_clr),
        .en     (acc_en),
        .centre (centre),
        .k      (sel.k),
        .a      (rd_hi),
        .b      (rd_lo),
        .acc    (acc)
    );

    fir_dec_out u_out (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .acc       (acc),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/fir_decim8_checker.sv
module fir_decim8_checker
    import fir_dec_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    busy,
    input logic [PTR_W-1:0]        wr_ptr,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data
);

    localparam logic [7:0] MIN_GAP = 8'(HALF + 2);

    logic [7:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= 8'hFF;
        end else if (out_valid) begin
            gap <= '0;
        end else if (gap != 8'hFF) begin
            gap <= gap + 1'b1;
        end
    end

    // R3: result strobe lasts a single cycle
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3: two results are separated by at least the computation window
    assert_output_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (gap >= MIN_GAP));

    // R7: no sample is written while a result is pending
    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wr_ptr));

    // R2: write pointer stays inside the history
    assert_ptr_range_R2: assert property (@(posedge clk) disable iff (rst)
        wr_ptr < PTR_W'(TAPS));

    // R8: output value holds between strobes
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

bind fir_decim8 fir_decim8_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .wr_ptr    (wr_ptr),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/fir_decim8_bench.sv
module fir_decim8_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_data = '0;
    logic               out_valid;
    logic signed [15:0] out_data;

    int checks = 0;
    int errors = 0;
    string seg_tag = "R1";

    always #2 clk = ~clk;

    fir_decim8 u_fir_decim8 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // ---------------- behavioural reference ----------------
    int  hist[$];
    int  pend = 0;
    int  grp = 0;
    int  pend_val = 0;
    bit  exp_ov = 0;
    int  exp_data = 0;
    bit  started = 0;

    function automatic int weight(int j);
        int m;
        m = (j < 48 - j) ? j : 48 - j;
        return 16 * (m + 1);
    endfunction

    function automatic int ref_result();
        longint s;
        s = 0;
        for (int j = 0; j < 49; j++) begin
            if (j < hist.size()) s += longint'(weight(j)) * longint'(hist[j]);
        end
        s = s + 128;
        s = s >>> 8;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    always @(posedge clk) begin
        bit take;
        started = 1;
        if (rst) begin
            hist.delete();
            pend = 0; grp = 0; exp_ov = 0; exp_data = 0;
        end else begin
            take = in_valid && (pend == 0);
            exp_ov = 0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    exp_ov = 1;
                    exp_data = pend_val;
                end
            end
            if (take) begin
                hist.push_front(int'(in_data));
                if (hist.size() > 49) void'(hist.pop_back());
                grp++;
                if (grp == 8) begin
                    grp = 0;
                    pend = 26;
                    pend_val = ref_result();
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (out_valid !== exp_ov) begin
                errors++;
                $display("FAIL %s out_valid actual %0b expected %0b (%s)",
                         rst ? "R1" : "R3", out_valid, exp_ov, seg_tag);
            end
            checks++;
            if (int'(out_data) != exp_data) begin
                errors++;
                $display("FAIL %s out_data actual %0d expected %0d",
                         rst ? "R1" : (exp_ov ? seg_tag : "R8 hold"),
                         out_data, exp_data);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input int v, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 12'(v);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic stream(input int v, input int n);
        for (int i = 0; i < n; i++) send(v, 28);
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 12'($urandom_range(0, 4095));
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seg_tag = "R1";
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R4 impulse: weights appear in history order (also shows R1 zero history)
        seg_tag = "R4 impulse";
        send(1000, 0);
        for (int i = 0; i < 63; i++) send(0, 0);
        repeat (40) @(negedge clk);

        // R5 rounding with small constants
        seg_tag = "R5 rounding";
        stream(3, 64);
        stream(-3, 64);
        stream(1, 64);

        // R4 level just below the limit
        seg_tag = "R4 dc";
        stream(800, 64);

        // R6 saturation in both directions
        seg_tag = "R6 saturate";
        stream(2047, 64);
        stream(-2048, 64);
        stream(-800, 64);

        // R7 continuous strobe: dropped samples during computation
        seg_tag = "R7 drop";
        burst(600);
        repeat (40) @(negedge clk);

        // R2 randomly spaced samples
        seg_tag = "R2 random";
        for (int i = 0; i < 400; i++) send(int'($urandom_range(0, 4095)) - 2048,
                                           int'($urandom_range(0, 6)));
        repeat (40) @(negedge clk);

        // R1 reset mid-stream clears history and outputs
        seg_tag = "R1 reset";
        send(1500, 0);
        send(1500, 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        seg_tag = "R4 after reset";
        send(500, 0);
        for (int i = 0; i < 15; i++) send(0, 0);
        repeat (40) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule